// File: doc/BRIEF.md
# External Associative-Data SRAM Access Sequencer

This block lets a host read and write the external SRAM that holds associative data behind a search-engine device. The host issues a command over two clock cycles on its command and data buses. The block checks that the command targets the SRAM address space and names this device. It then forms a 22-bit SRAM address and plays out the SRAM address bus, an active-low chip enable, an active-low address latch enable, a data-bus drive window and an acknowledge line. Every tri-stated signal is modelled as a value plus an output enable, so each high-impedance window can be seen at the ports.

The output timing reuses the search path's latency. A 2-bit search-latency setting S delays the address. A read is blocking: the block holds busy until its acknowledge has gone high and then low, and it flags any command that arrives during that time. A 3-bit hold-latency setting H delays the acknowledge further. A write is pipelined: it only produces an address strobe some cycles later, and the next command may start in the cycle after the write's second command cycle.

Cycle numbers below count from the cycle in which the first command cycle (A) is presented. The second command cycle (B) is A+1.

States and transitions:
- `ST_IDLE` goes to `ST_CMD_B` on a valid first cycle. Otherwise it stays in `ST_IDLE`.
- `ST_CMD_B` goes to `ST_RD_WAIT` on a read second cycle. It goes back to `ST_IDLE` on a write second cycle, after pushing the write into the delay pipe. It also goes back to `ST_IDLE` on a malformed second cycle.
- `ST_RD_WAIT` lasts 2+S cycles and then goes to `ST_RD_DRIVE`.
- `ST_RD_DRIVE` goes to `ST_RD_ADDR`.
- `ST_RD_ADDR` goes to `ST_RD_END` when H is 0, and to `ST_RD_HOLD` otherwise.
- `ST_RD_HOLD` lasts H cycles and then goes to `ST_RD_END`.
- `ST_RD_END` goes to `ST_IDLE`.

Top module: `sram_pio_seq`

## Requirements
- R1: A command is accepted only if all of the following hold:
  - `cmd_valid` is high in both cycle A and cycle B.
  - `cmd_code` is the same in both cycles and is either read (2'b01) or write (2'b10).
  - `dq_in[20:19]` equals 2'b10 in both cycles.

  Any other pattern causes no output activity.
- R2: A command is accepted only if `dq_in[25:21]` in cycle A equals `dev_id`. A command naming another ID causes no output activity.
- R3: The SRAM address driven is `{cmd_hi, 1'b0, dq_in[18:0]}`, with all fields taken from cycle A.
- R4: For a read, `sadr_oe` is high, and `ce_n` and `ale_n` are low, for exactly one cycle, at A+5+S. Outside such strobes `sadr_oe` is low and `ce_n`/`ale_n` are high.
- R5: For a read, `dq_oe` is high from A+4+S through A+5+S+H.
- R6: For a read, `ack_oe` is high from A+4+S through A+6+S+H. `ack_val` is high only at A+5+S+H and is driven low in the other enabled cycles.
- R7: For a read, `busy` is high from A+2 through A+6+S+H. A new command may start at A+7+S+H.
- R8: `cmd_valid` while `busy` is high is ignored and raises `proto_err` in that same cycle.
- R9: A write produces one address/chip-enable/latch-enable strobe at B+5+S, with no acknowledge, no data-bus drive and no busy. The next command may start at B+1.
- R10: After reset:
  - all output enables are low;
  - `ce_n` and `ale_n` are high;
  - `busy` and `proto_err` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| dev_id | input | 5 | This device's ID |
| cfg_srch_lat | input | 2 | Search-path latency S (must be stable during an access) |
| cfg_hold_lat | input | 3 | Acknowledge hold latency H (must be stable during an access) |
| cmd_valid | input | 1 | Command valid |
| cmd_code | input | 2 | Instruction code: 01 read, 10 write |
| cmd_hi | input | 2 | Upper SRAM address bits, taken in cycle A |
| dq_in | input | 26 | Host data bus: ID [25:21], space [20:19], address [18:0] |
| sadr_val | output | 22 | SRAM address value |
| sadr_oe | output | 1 | SRAM address bus drive enable |
| ce_n | output | 1 | SRAM chip enable, active low |
| ale_n | output | 1 | SRAM address latch enable, active low |
| ack_val | output | 1 | Acknowledge value |
| ack_oe | output | 1 | Acknowledge drive enable |
| dq_oe | output | 1 | Host data bus drive enable |
| busy | output | 1 | Blocking read in progress |
| proto_err | output | 1 | Command presented while busy |

## Verification
Reads and writes are issued with random addresses, upper bits and code mixes, under random S and H settings. Comparing every output against a per-cycle expected map distinguishes off-by-one latency errors in the address path from those in the acknowledge path.

Several malformed commands are injected to show that each acceptance condition is checked on its own:
- a foreign ID;
- a wrong address space;
- an unused code;
- a second cycle whose code does not match the first.

Back-to-back writes followed by an immediate read separate pipelined from blocking behaviour. Random command noise injected inside read windows exercises the protocol-error flag, and its absence of effect on the read's own timing.

// File: rtl/sram_pio_pkg.sv
package sram_pio_pkg;

    localparam logic [1:0] OP_READ    = 2'b01;
    localparam logic [1:0] OP_WRITE   = 2'b10;
    localparam logic [1:0] SPACE_SRAM = 2'b10;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_CMD_B,
        ST_RD_WAIT,
        ST_RD_DRIVE,
        ST_RD_ADDR,
        ST_RD_HOLD,
        ST_RD_END
    } pio_state_e;

endpackage

// File: rtl/sram_pio_decode.sv
module sram_pio_decode #(
    parameter int ID_W  = 5,
    parameter int ADR_W = 19
) (
    input  logic                     cmd_valid,
    input  logic [1:0]               cmd_code,
    input  logic [ADR_W+2+ID_W-1:0]  dq_in,
    input  logic [ID_W-1:0]          dev_id,
    output logic                     space_ok,
    output logic                     first_ok,
    output logic [ADR_W-1:0]         entry_adr
);
    import sram_pio_pkg::*;

    localparam int SPACE_LSB = ADR_W;
    localparam int ID_LSB    = ADR_W + 2;

    logic id_hit;
    logic op_known;

    always_comb begin
        id_hit    = (dq_in[ID_LSB +: ID_W] == dev_id);
        space_ok  = (dq_in[SPACE_LSB +: 2] == SPACE_SRAM);
        op_known  = (cmd_code == OP_READ) || (cmd_code == OP_WRITE);
        first_ok  = cmd_valid && id_hit && space_ok && op_known;
        entry_adr = dq_in[ADR_W-1:0];
    end

endmodule

// File: rtl/sram_pio_fsm.sv
module sram_pio_fsm #(
    parameter int SL_W = 2,
    parameter int HL_W = 3
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            cmd_valid,
    input  logic [1:0]      cmd_code,
    input  logic            first_ok,
    input  logic            space_ok,
    input  logic [SL_W-1:0] srch_lat,
    input  logic [HL_W-1:0] hold_lat,
    output logic            take_a,
    output logic            wr_push,
    output logic            busy,
    output logic            dq_oe,
    output logic            ack_oe,
    output logic            ack_val,
    output logic            rd_addr_cycle
);
    import sram_pio_pkg::*;

    localparam int CNT_W = ((SL_W > HL_W) ? SL_W : HL_W) + 1;

    pio_state_e       state_q, state_d;
    logic [CNT_W-1:0] cnt_q, cnt_d;
    logic [1:0]       code_q, code_d;
    logic             second_ok;

    assign second_ok = cmd_valid && space_ok && (cmd_code == code_q);

    // next state
    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        code_d  = code_q;
        unique case (state_q)
            ST_IDLE: begin
                if (first_ok) begin
                    state_d = ST_CMD_B;
                    code_d  = cmd_code;
                end
            end
            ST_CMD_B: begin
                if (second_ok && code_q == OP_READ) begin
                    state_d = ST_RD_WAIT;
                    cnt_d   = CNT_W'(srch_lat) + CNT_W'(1);
                end else begin
                    state_d = ST_IDLE;
                end
            end
            ST_RD_WAIT: begin
                if (cnt_q == '0) state_d = ST_RD_DRIVE;
                else             cnt_d   = cnt_q - CNT_W'(1);
            end
            ST_RD_DRIVE: state_d = ST_RD_ADDR;
            ST_RD_ADDR: begin
                if (hold_lat == '0) begin
                    state_d = ST_RD_END;
                end else begin
                    state_d = ST_RD_HOLD;
                    cnt_d   = CNT_W'(hold_lat);
                end
            end
            ST_RD_HOLD: begin
                if (cnt_q == CNT_W'(1)) state_d = ST_RD_END;
                else                    cnt_d   = cnt_q - CNT_W'(1);
            end
            ST_RD_END: state_d = ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            cnt_q   <= '0;
            code_q  <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
            code_q  <= code_d;
        end
    end

    // outputs
    always_comb begin
        take_a        = (state_q == ST_IDLE) && first_ok;
        wr_push       = (state_q == ST_CMD_B) && second_ok && (code_q == OP_WRITE);
        busy          = 1'b0;
        dq_oe         = 1'b0;
        ack_oe        = 1'b0;
        ack_val       = 1'b0;
        rd_addr_cycle = 1'b0;
        unique case (state_q)
            ST_IDLE, ST_CMD_B: ;
            ST_RD_WAIT: busy = 1'b1;
            ST_RD_DRIVE: begin
                busy   = 1'b1;
                dq_oe  = 1'b1;
                ack_oe = 1'b1;
            end
            ST_RD_ADDR: begin
                busy          = 1'b1;
                dq_oe         = 1'b1;
                ack_oe        = 1'b1;
                ack_val       = (hold_lat == '0);
                rd_addr_cycle = 1'b1;
            end
            ST_RD_HOLD: begin
                busy    = 1'b1;
                dq_oe   = 1'b1;
                ack_oe  = 1'b1;
                ack_val = (cnt_q == CNT_W'(1));
            end
            ST_RD_END: begin
                busy   = 1'b1;
                ack_oe = 1'b1;
            end
            default: ;
        endcase
    end

    AST_BUSY_BLOCKS_CMD: assert property (@(posedge clk) disable iff (!rst_n) busy |=> (state_q != ST_CMD_B)); // R8
    AST_ACK_SINGLE_HIGH: assert property (@(posedge clk) disable iff (!rst_n) ack_val |=> (ack_oe && !ack_val)); // R6
    AST_ACK_ENTERS_LOW: assert property (@(posedge clk) disable iff (!rst_n) $rose(ack_oe) |-> !ack_val); // R6

endmodule

// File: rtl/sram_pio_wr_pipe.sv
module sram_pio_wr_pipe #(
    parameter int SADR_W = 22,
    parameter int SL_W   = 2,
    parameter int BASE   = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              push,
    input  logic [SADR_W-1:0] push_adr,
    input  logic [SL_W-1:0]   srch_lat,
    output logic              fire,
    output logic [SADR_W-1:0] fire_adr
);
    localparam int DEPTH = BASE + (1 << SL_W);
    localparam int IDX_W = $clog2(DEPTH);

    logic [DEPTH-1:0]  vld_q;
    logic [SADR_W-1:0] adr_q [DEPTH];
    logic [IDX_W-1:0]  ins_idx;

    assign ins_idx = IDX_W'(BASE) + IDX_W'(srch_lat);

    for (genvar i = 0; i < DEPTH; i++) begin : g_stage
        logic              nxt_vld;
        logic [SADR_W-1:0] nxt_adr;
        if (i == DEPTH - 1) begin : g_top
            assign nxt_vld = 1'b0;
            assign nxt_adr = '0;
        end else begin : g_mid
            assign nxt_vld = vld_q[i+1];
            assign nxt_adr = adr_q[i+1];
        end
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                vld_q[i] <= 1'b0;
                adr_q[i] <= '0;
            end else if (push && ins_idx == IDX_W'(i)) begin
                vld_q[i] <= 1'b1;
                adr_q[i] <= push_adr;
            end else begin
                vld_q[i] <= nxt_vld;
                adr_q[i] <= nxt_adr;
            end
        end
    end

    assign fire     = vld_q[0];
    assign fire_adr = adr_q[0];

endmodule

// File: rtl/sram_pio_seq.sv
module sram_pio_seq #(
    parameter int ID_W  = 5,
    parameter int ADR_W = 19,
    parameter int SL_W  = 2,
    parameter int HL_W  = 3
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [ID_W-1:0]         dev_id,
    input  logic [SL_W-1:0]         cfg_srch_lat,
    input  logic [HL_W-1:0]         cfg_hold_lat,
    input  logic                    cmd_valid,
    input  logic [1:0]              cmd_code,
    input  logic [1:0]              cmd_hi,
    input  logic [ADR_W+2+ID_W-1:0] dq_in,
    output logic [ADR_W+2:0]        sadr_val,
    output logic                    sadr_oe,
    output logic                    ce_n,
    output logic                    ale_n,
    output logic                    ack_val,
    output logic                    ack_oe,
    output logic                    dq_oe,
    output logic                    busy,
    output logic                    proto_err
);
    localparam int SADR_W   = ADR_W + 3;
    localparam int BASE_LAT = 4;

    logic              space_ok, first_ok, take_a, wr_push, rd_addr_cycle;
    logic              wr_fire;
    logic [ADR_W-1:0]  entry_adr;
    logic [SADR_W-1:0] adr_q, wr_adr;

    sram_pio_decode #(.ID_W(ID_W), .ADR_W(ADR_W)) u_decode (
        .cmd_valid (cmd_valid),
        .cmd_code  (cmd_code),
        .dq_in     (dq_in),
        .dev_id    (dev_id),
        .space_ok  (space_ok),
        .first_ok  (first_ok),
        .entry_adr (entry_adr)
    );

    sram_pio_fsm #(.SL_W(SL_W), .HL_W(HL_W)) u_fsm (
        .clk           (clk),
        .rst_n         (rst_n),
        .cmd_valid     (cmd_valid),
        .cmd_code      (cmd_code),
        .first_ok      (first_ok),
        .space_ok      (space_ok),
        .srch_lat      (cfg_srch_lat),
        .hold_lat      (cfg_hold_lat),
        .take_a        (take_a),
        .wr_push       (wr_push),
        .busy          (busy),
        .dq_oe         (dq_oe),
        .ack_oe        (ack_oe),
        .ack_val       (ack_val),
        .rd_addr_cycle (rd_addr_cycle)
    );

    always_ff @(posedge clk) begin
        if (!rst_n)      adr_q <= '0;
        else if (take_a) adr_q <= {cmd_hi, 1'b0, entry_adr};
    end

    sram_pio_wr_pipe #(.SADR_W(SADR_W), .SL_W(SL_W), .BASE(BASE_LAT)) u_wr_pipe (
        .clk      (clk),
        .rst_n    (rst_n),
        .push     (wr_push),
        .push_adr (adr_q),
        .srch_lat (cfg_srch_lat),
        .fire     (wr_fire),
        .fire_adr (wr_adr)
    );

    always_comb begin
        sadr_oe   = rd_addr_cycle || wr_fire;
        ce_n      = !sadr_oe;
        ale_n     = !sadr_oe;
        sadr_val  = wr_fire ? wr_adr : (rd_addr_cycle ? adr_q : '0);
        proto_err = cmd_valid && busy;
    end

    AST_WR_READ_APART: assert property (@(posedge clk) disable iff (!rst_n) wr_fire |-> !rd_addr_cycle); // R9
    AST_BUSY_ENDS_ACK_LOW: assert property (@(posedge clk) disable iff (!rst_n) $fell(busy) |-> ($past(ack_oe) && !$past(ack_val))); // R7
    AST_NO_STROBE_WITH_ACK_HIGH: assert property (@(posedge clk) disable iff (!rst_n) (ack_val && cfg_hold_lat != '0) |-> ce_n); // R4

endmodule

// File: tb/sram_pio_seq_tb.sv
`timescale 1ns/1ps
module sram_pio_seq_tb;

    localparam int EXP_N = 4096;
    localparam logic [4:0] MY_ID = 5'h0B;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  srch = 2'd0;
    logic [2:0]  hold = 3'd0;
    logic        cmd_valid = 1'b0;
    logic [1:0]  cmd_code = 2'd0;
    logic [1:0]  cmd_hi = 2'd0;
    logic [25:0] dq_in = '0;
    logic [21:0] sadr_val;
    logic        sadr_oe, ce_n, ale_n, ack_val, ack_oe, dq_oe, busy, proto_err;

    sram_pio_seq u_dut (
        .clk(clk), .rst_n(rst_n), .dev_id(MY_ID),
        .cfg_srch_lat(srch), .cfg_hold_lat(hold),
        .cmd_valid(cmd_valid), .cmd_code(cmd_code), .cmd_hi(cmd_hi), .dq_in(dq_in),
        .sadr_val(sadr_val), .sadr_oe(sadr_oe), .ce_n(ce_n), .ale_n(ale_n),
        .ack_val(ack_val), .ack_oe(ack_oe), .dq_oe(dq_oe), .busy(busy), .proto_err(proto_err)
    );

    always #10 clk = ~clk;

    int n_checks = 0;
    int n_errors = 0;
    int cyc = 0;
    int strobes = 0;
    bit mon_on = 1'b0;
    bit done = 1'b0;

    bit          e_sadr_oe [EXP_N];
    logic [21:0] e_sadr    [EXP_N];
    bit          e_dq_oe   [EXP_N];
    bit          e_ack_oe  [EXP_N];
    bit          e_ack     [EXP_N];
    bit          e_busy    [EXP_N];
    bit          e_perr    [EXP_N];

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_errors++;
            $display("FAIL %s cyc=%0d actual=%0h expected=%0h", tag, cyc, act, exp);
        end
    endtask

    function automatic logic [21:0] exp_adr(input logic [1:0] hi, input logic [18:0] a);
        return {hi, 1'b0, a};
    endfunction

    always @(posedge clk) if (rst_n) cyc = cyc + 1;

    always @(negedge clk) begin
        if (mon_on && cyc < EXP_N) begin
            chk(sadr_oe === e_sadr_oe[cyc], "R4 sadr_oe", 32'(sadr_oe), 32'(e_sadr_oe[cyc]));
            if (e_sadr_oe[cyc]) chk(sadr_val === e_sadr[cyc], "R3 sadr_val", 32'(sadr_val), 32'(e_sadr[cyc]));
            chk(ce_n === !e_sadr_oe[cyc], "R4 ce_n", 32'(ce_n), 32'(!e_sadr_oe[cyc]));
            chk(ale_n === !e_sadr_oe[cyc], "R4 ale_n", 32'(ale_n), 32'(!e_sadr_oe[cyc]));
            chk(dq_oe === e_dq_oe[cyc], "R5 dq_oe", 32'(dq_oe), 32'(e_dq_oe[cyc]));
            chk(ack_oe === e_ack_oe[cyc], "R6 ack_oe", 32'(ack_oe), 32'(e_ack_oe[cyc]));
            if (e_ack_oe[cyc]) chk(ack_val === e_ack[cyc], "R6 ack_val", 32'(ack_val), 32'(e_ack[cyc]));
            chk(busy === e_busy[cyc], "R7 busy", 32'(busy), 32'(e_busy[cyc]));
            chk(proto_err === e_perr[cyc], "R8 proto_err", 32'(proto_err), 32'(e_perr[cyc]));
            if (sadr_oe === 1'b1) strobes++;
        end
    end

    task automatic drive_idle(input int k);
        for (int i = 0; i < k; i++) begin
            @(posedge clk); #1;
            cmd_valid = 1'b0;
            cmd_code  = 2'($urandom);
            cmd_hi    = 2'($urandom);
            dq_in     = 26'($urandom);
        end
    endtask

    // kind: 0 good, 1 foreign id, 2 wrong space, 3 unused code, 4 second-cycle code mismatch
    task automatic issue(input logic [1:0] op, input int kind, input bit junk);
        int c;
        logic [1:0]  hi   = 2'($urandom);
        logic [18:0] a    = 19'($urandom);
        logic [4:0]  id   = (kind == 1) ? (MY_ID ^ 5'(1 + $urandom % 31)) : MY_ID;
        logic [1:0]  sp   = (kind == 2) ? 2'(($urandom % 3) == 0 ? 0 : (($urandom % 2) ? 1 : 3)) : 2'b10;
        logic [1:0]  codeA = (kind == 3) ? (($urandom % 2) ? 2'b00 : 2'b11) : op;
        logic [1:0]  codeB = (kind == 4) ? ((op == 2'b01) ? 2'b10 : 2'b01) : codeA;
        int s = int'(srch);
        int h = int'(hold);
        @(posedge clk); #1;
        c = cyc;
        cmd_valid = 1'b1; cmd_code = codeA; cmd_hi = hi; dq_in = {id, sp, a};
        @(posedge clk); #1;
        cmd_valid = 1'b1; cmd_code = codeB; cmd_hi = 2'($urandom); dq_in = {id, sp, 19'($urandom)};
        if (kind == 0 && op == 2'b10) begin
            if (c + 6 + s < EXP_N) begin
                e_sadr_oe[c+6+s] = 1'b1;
                e_sadr[c+6+s]    = exp_adr(hi, a);
            end
        end else if (kind == 0) begin
            if (c + 7 + s + h < EXP_N) begin
                for (int n = 2; n <= 6 + s + h; n++) e_busy[c+n] = 1'b1;
                for (int n = 4 + s; n <= 5 + s + h; n++) e_dq_oe[c+n] = 1'b1;
                for (int n = 4 + s; n <= 6 + s + h; n++) e_ack_oe[c+n] = 1'b1;
                e_ack[c+5+s+h]    = 1'b1;
                e_sadr_oe[c+5+s]  = 1'b1;
                e_sadr[c+5+s]     = exp_adr(hi, a);
            end
            for (int n = 2; n <= 6 + s + h; n++) begin
                @(posedge clk); #1;
                cmd_valid = junk && ($urandom % 2 == 1);
                cmd_code  = 2'($urandom);
                cmd_hi    = 2'($urandom);
                dq_in     = {(($urandom % 2) ? MY_ID : 5'($urandom)), 2'b10, 19'($urandom)};
                if (cmd_valid && c + n < EXP_N) e_perr[c+n] = 1'b1;
            end
        end
    endtask

    initial begin
        int base;
        void'($urandom(32'd20240611));
        for (int i = 0; i < EXP_N; i++) begin
            e_sadr_oe[i] = 0; e_sadr[i] = '0; e_dq_oe[i] = 0; e_ack_oe[i] = 0;
            e_ack[i] = 0; e_busy[i] = 0; e_perr[i] = 0;
        end
        repeat (4) @(posedge clk);
        #1;
        // R10: reset values
        chk(sadr_oe === 1'b0 && ack_oe === 1'b0 && dq_oe === 1'b0, "R10 enables in reset", {sadr_oe, ack_oe, dq_oe}, 0);
        chk(ce_n === 1'b1 && ale_n === 1'b1, "R10 strobes idle in reset", {ce_n, ale_n}, 3);
        chk(busy === 1'b0 && proto_err === 1'b0, "R10 busy/err in reset", {busy, proto_err}, 0);
        @(negedge clk);
        rst_n = 1'b1;
        mon_on = 1'b1;
        drive_idle(3);

        // directed: zero latency read (R4 R5 R6 R7)
        srch = 2'd0; hold = 3'd0;
        issue(2'b01, 0, 1'b0);
        drive_idle(2);

        // directed: rejected commands leave no strobe (R1 R2)
        base = strobes;
        issue(2'b01, 1, 1'b0);
        issue(2'b10, 1, 1'b0);
        drive_idle(10);
        chk(strobes == base, "R2 foreign id ignored", strobes, base);
        base = strobes;
        issue(2'b01, 2, 1'b0);
        issue(2'b10, 3, 1'b0);
        issue(2'b01, 4, 1'b0);
        issue(2'b10, 4, 1'b0);
        drive_idle(10);
        chk(strobes == base, "R1 malformed command ignored", strobes, base);

        // directed: back-to-back writes then a read (R9)
        srch = 2'd2; hold = 3'd1;
        base = strobes;
        issue(2'b10, 0, 1'b0);
        issue(2'b10, 0, 1'b0);
        issue(2'b01, 0, 1'b1);
        drive_idle(12);
        chk(strobes == base + 3, "R9 pipelined writes and read strobes", strobes, base + 3);

        // directed: maximum latencies with noise (R8)
        srch = 2'd3; hold = 3'd7;
        issue(2'b01, 0, 1'b1);
        issue(2'b10, 0, 1'b0);
        drive_idle(12);

        // random episodes
        for (int ep = 0; ep < 10; ep++) begin
            srch = 2'($urandom);
            hold = 3'($urandom);
            drive_idle(2);
            for (int k = 0; k < 12; k++) begin
                int r = $urandom % 10;
                if (r < 4)      issue(2'b01, 0, ($urandom % 2) == 1);
                else if (r < 8) issue(2'b10, 0, 1'b0);
                else            issue(($urandom % 2) ? 2'b01 : 2'b10, 1 + $urandom % 4, 1'b0);
            end
            drive_idle(14);
        end

        mon_on = 1'b0;
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", n_checks, n_errors);
        $finish;
    end

    initial begin
        #(64'd200000 * 20);
        if (!done) begin
            n_checks++;
            n_errors++;
            $display("FAIL watchdog expired actual=running expected=done");
            $display("CHECKS %0d ERRORS %0d", n_checks, n_errors);
            $finish;
        end
    end

endmodule